// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port whose behaviour is set by one 8-bit control register. The register selects the frame format and bit-rate source, enables reception, carries the outgoing ninth bit, and holds the last received ninth bit. It also holds two sticky completion flags, one for transmit and one for receive. A CPU writes and reads the control register, writes a byte to start a transmission, and reads the last accepted received byte from a dedicated output.

Three active formats exist. The first is an 8-bit frame at a variable rate. The other two are 9-bit frames, one at a fixed divide of the block clock and one at the variable rate. The variable rate arrives as a tick input from an external timer. The receiver oversamples each bit 16 times, validates the start bit at mid-bit, and takes a majority vote of three samples at each bit centre.

An address filter can reject frames without disturbing software state. In the 9-bit formats it drops frames whose ninth bit is 0. In the 8-bit format it drops frames with a bad stop bit. A rejected frame leaves the receive flag, the receive buffer and the stored ninth bit unchanged, so only address frames wake the CPU in a multi-drop bus setup.

Top module: `uart_mp`

## Requirements
- R1: After reset the control register reads 00h, `txd` is high (idle) and `rx_data` is 00h.
- R2: Control register bits are, MSB to LSB: format select high, format select low, address filter enable, receive enable, transmit ninth bit, received ninth bit, transmit-done flag, receive-done flag. A control write loads all eight bits, and a read returns them. Format select {bit7,bit6} is decoded as follows: 00 is inactive, 01 is an 8-bit frame at the variable rate, 10 is a 9-bit frame at the fixed rate, and 11 is a 9-bit frame at the variable rate.
- R3: In the 9-bit formats, bit 3 is sent as the ninth bit and the received ninth bit is stored in bit 2. With the filter (bit 5) set, a frame whose ninth bit is 0 does not set bit 0 and leaves `rx_data` and bit 2 unchanged.
- R4: In the 8-bit format with the filter clear, bit 2 receives the sampled stop bit. With the filter set, a frame whose stop bit samples 0 is dropped, leaving bit 0, bit 2 and `rx_data` unchanged.
- R5: The transmit-done flag (bit 1) is set at the start of the transmitted stop bit and is clear earlier in the frame.
- R6: The receive-done flag (bit 0) is set at about 9/16 of the received stop bit and is clear before the middle of that bit. Neither flag is ever cleared by hardware; only a control write clears them.
- R7: A transmitted frame is a start bit (0), then 8 data bits LSB first, then the ninth bit in 9-bit formats, then a stop bit (1). The line idles high.
- R8: A data write is ignored while a frame is in progress, stop bit included, and whenever the format select is 00.
- R9: Frames are received only while receive enable (bit 4) is 1. A frame sent while it is 0 changes neither the flags nor `rx_data`.
- R10: In the fixed-rate format a bit lasts FIX_DIV clocks, or FIX_DIV/2 while `rate_dbl` is 1. In the variable formats a bit lasts 16 `var_tick` pulses.
- R11: A falling edge on `rxd` starts a frame only if the line is still low at the middle of the start bit. A single-sample pulse at a data bit centre is outvoted by the other two samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (oscillator) |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_dbl | input | 1 | Halves the fixed-rate bit time |
| var_tick | input | 1 | External tick, 16 per bit in the variable formats |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register contents |
| data_wr | input | 1 | Transmit byte write strobe |
| data_wdata | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last accepted received byte |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The transmitter is driven with bytes that have alternating bits, a single set LSB, and a single set MSB. This tells a correct LSB-first order from a reversed or shifted one. The same bytes are sent with the ninth bit both set and clear, and at three bit rates, so a wrong ninth bit or a wrong divider fails the decode. The receiver gets frames with good and bad stop bits and with ninth bits of 0 and 1, each under filter on and filter off. These pairs separate the accept path from the drop path and show that a drop leaves the buffer alone. A short start pulse and a one-sample glitch at a data-bit centre separate true start validation and voting from a plain edge trigger and a single-sample decode.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;

   typedef enum logic [1:0] {
      FMT_OFF = 2'b00,
      FMT_8V  = 2'b01,
      FMT_9F  = 2'b10,
      FMT_9V  = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_st_e;

endpackage

// File: rtl/uart_mp_tick.sv
module uart_mp_tick #(
   parameter int FIX_DIV = 64,
   parameter int OVS     = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] fmt,
   input  logic       rate_dbl,
   input  logic       var_tick,
   output logic       tick
);
   import uart_mp_pkg::*;

   localparam int FIX_TICK = FIX_DIV / OVS;
   localparam int CW       = $clog2(FIX_TICK + 1);

   if ((FIX_DIV % (2 * OVS)) != 0 || FIX_DIV < 2 * OVS) begin : g_bad_div
      $error("FIX_DIV must be a multiple of 2*OVS");
   end

   logic [CW-1:0] div_cnt;
   logic [CW-1:0] lim_m1;
   logic          fix_hit;

   assign lim_m1  = rate_dbl ? CW'(FIX_TICK / 2 - 1) : CW'(FIX_TICK - 1);
   assign fix_hit = (div_cnt >= lim_m1);

   always_ff @(posedge clk) begin
      if (!rst_n)                div_cnt <= '0;
      else if (fmt != FMT_9F)    div_cnt <= '0;
      else if (fix_hit)          div_cnt <= '0;
      else                       div_cnt <= div_cnt + CW'(1);
   end

   always_comb begin
      case (fmt)
         FMT_9F:  tick = fix_hit;
         FMT_OFF: tick = 1'b0;
         default: tick = var_tick;
      endcase
   end

endmodule

// File: rtl/uart_mp_tx.sv
module uart_mp_tx #(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       nine,
   input  logic       tb9,
   input  logic       load_req,
   input  logic [7:0] din,
   output logic       txd,
   output logic       busy,
   output logic       done
);
   localparam int PW = $clog2(OVS);

   if ((OVS & (OVS - 1)) != 0 || OVS < 8) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 8");
   end

   logic [PW-1:0] ph;
   logic [10:0]   sh;
   logic [3:0]    rem;
   logic          bit_end;

   assign bit_end = tick && (ph == PW'(OVS - 1));
   assign txd     = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sh   <= '1;
         rem  <= '0;
         ph   <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (load_req) begin
               busy <= 1'b1;
               sh   <= {1'b1, (nine ? tb9 : 1'b1), din, 1'b0};
               rem  <= nine ? 4'd11 : 4'd10;
               ph   <= '0;
            end
         end else if (tick) begin
            ph <= ph + PW'(1);
            if (bit_end) begin
               if (rem == 4'd1) begin
                  busy <= 1'b0;
               end else begin
                  sh  <= {1'b1, sh[10:1]};
                  rem <= rem - 4'd1;
                  if (rem == 4'd2) done <= 1'b1;
               end
            end
         end
      end
   end

   assert_done_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (txd && busy && rem == 4'd1))
      else $error("done pulse outside stop bit");

   assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && load_req && !bit_end) |=> ($stable(sh) && $stable(rem)))
      else $error("frame disturbed by write while busy");

endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx #(
   parameter int OVS = 16,
   parameter bit MAJ = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       nine,
   input  logic       filt,
   input  logic       rxd,
   output logic       ok,
   output logic [7:0] frm_data,
   output logic       frm_b9
);
   import uart_mp_pkg::*;

   localparam int PW      = $clog2(OVS);
   localparam int VOTE_PH = OVS / 2 + 1;

   if ((OVS & (OVS - 1)) != 0 || OVS < 8) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 8");
   end

   logic [1:0]    sy;
   logic          rx_s;
   logic [1:0]    hist;
   logic          vote;
   rx_st_e        st;
   logic [PW-1:0] ph;
   logic [3:0]    cnt;
   logic [8:0]    sh;
   logic [3:0]    nbits;
   logic          at_vote;
   logic          at_end;

   assign rx_s    = sy[1];
   assign nbits   = nine ? 4'd9 : 4'd8;
   assign at_vote = (ph == PW'(VOTE_PH));
   assign at_end  = (ph == PW'(OVS - 1));

   if (MAJ) begin : g_maj
      assign vote = (hist[1] & hist[0]) | (hist[1] & rx_s) | (hist[0] & rx_s);
   end else begin : g_ctr
      assign vote = hist[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sy       <= 2'b11;
         hist     <= 2'b11;
         st       <= RX_IDLE;
         ph       <= '0;
         cnt      <= '0;
         sh       <= '0;
         ok       <= 1'b0;
         frm_data <= '0;
         frm_b9   <= 1'b0;
      end else begin
         sy <= {sy[0], rxd};
         ok <= 1'b0;
         if (tick) hist <= {hist[0], rx_s};
         if (!en) begin
            st <= RX_IDLE;
         end else if (tick) begin
            case (st)
               RX_IDLE: begin
                  if (hist[0] && !rx_s) begin
                     st <= RX_START;
                     ph <= PW'(1);
                  end
               end
               RX_START: begin
                  ph <= ph + PW'(1);
                  if (at_vote) begin
                     if (vote) st <= RX_IDLE;
                     else begin
                        st  <= RX_DATA;
                        cnt <= '0;
                     end
                  end
               end
               RX_DATA: begin
                  ph <= ph + PW'(1);
                  if (at_vote) begin
                     sh  <= {vote, sh[8:1]};
                     cnt <= cnt + 4'd1;
                  end
                  if (at_end && cnt == nbits) st <= RX_STOP;
               end
               default: begin
                  ph <= ph + PW'(1);
                  if (at_vote) begin
                     st       <= RX_IDLE;
                     ok       <= nine ? (!filt || sh[8]) : (!filt || vote);
                     frm_data <= nine ? sh[7:0] : sh[8:1];
                     frm_b9   <= nine ? sh[8] : vote;
                  end
               end
            endcase
         end
      end
   end

   assert_filter_ninth_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && nine && filt) |-> frm_b9)
      else $error("filtered 9-bit frame accepted with ninth bit 0");

   assert_filter_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && !nine && filt) |-> frm_b9)
      else $error("filtered 8-bit frame accepted with bad stop");

   assert_rx_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> $past(en))
      else $error("frame accepted while receive disabled");

endmodule

// File: rtl/uart_mp.sv
module uart_mp #(
   parameter int FIX_DIV = 64,
   parameter int OVS     = 16,
   parameter bit MAJ     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rate_dbl,
   input  logic       var_tick,
   input  logic       ctl_wr,
   input  logic [7:0] ctl_wdata,
   output logic [7:0] ctl_rdata,
   input  logic       data_wr,
   input  logic [7:0] data_wdata,
   output logic [7:0] rx_data,
   input  logic       rxd,
   output logic       txd
);
   import uart_mp_pkg::*;

   logic [1:0] fmt;
   logic       filt, rx_on, tx_b9, rx_b9, tx_flag, rx_flag;
   logic       tick, nine;
   logic       tx_busy, tx_done;
   logic       rx_ok, rx_fb9;
   logic [7:0] rx_fdata;

   assign nine      = fmt[1];
   assign ctl_rdata = {fmt, filt, rx_on, tx_b9, rx_b9, tx_flag, rx_flag};

   uart_mp_tick #(.FIX_DIV(FIX_DIV), .OVS(OVS)) u_tick (
      .clk(clk), .rst_n(rst_n), .fmt(fmt), .rate_dbl(rate_dbl),
      .var_tick(var_tick), .tick(tick)
   );

   uart_mp_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .nine(nine), .tb9(tx_b9),
      .load_req(data_wr && (fmt != FMT_OFF)), .din(data_wdata),
      .txd(txd), .busy(tx_busy), .done(tx_done)
   );

   uart_mp_rx #(.OVS(OVS), .MAJ(MAJ)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_on), .nine(nine),
      .filt(filt), .rxd(rxd), .ok(rx_ok), .frm_data(rx_fdata), .frm_b9(rx_fb9)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {fmt, filt, rx_on, tx_b9, rx_b9, tx_flag, rx_flag} <= 8'h00;
         rx_data <= 8'h00;
      end else begin
         if (ctl_wr) {fmt, filt, rx_on, tx_b9, rx_b9, tx_flag, rx_flag} <= ctl_wdata;
         if (tx_done) tx_flag <= 1'b1;
         if (rx_ok) begin
            rx_flag <= 1'b1;
            rx_b9   <= rx_fb9;
            rx_data <= rx_fdata;
         end
      end
   end

   assert_tx_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flag && !ctl_wr) |=> tx_flag)
      else $error("transmit flag cleared by hardware");

   assert_rx_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag && !ctl_wr) |=> rx_flag)
      else $error("receive flag cleared by hardware");

   assert_off_stays_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == FMT_OFF && !tx_busy) |=> !tx_busy)
      else $error("transmitter started while inactive");

   assert_rx_buf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ok |=> $stable(rx_data))
      else $error("receive buffer changed without accepted frame");

endmodule

// File: tb/sim_uart_mp.sv
module sim_uart_mp;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rate_dbl = 1'b0;
   logic       var_tick = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_rdata;
   logic       data_wr = 1'b0;
   logic [7:0] data_wdata = 8'h00;
   logic [7:0] rx_data;
   logic       rxd = 1'b1;
   logic       txd;

   int tests = 0;
   int fails = 0;
   int bit_clks = 32;
   int pushed = 0;
   int frames_seen = 0;
   logic [7:0] ctl_sh = 8'h00;
   logic       mon_nine = 1'b0;
   logic [8:0] exp_q[$];

   always #5 clk = ~clk;

   uart_mp u0 (
      .clk(clk), .rst_n(rst_n), .rate_dbl(rate_dbl), .var_tick(var_tick),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .data_wr(data_wr), .data_wdata(data_wdata), .rx_data(rx_data),
      .rxd(rxd), .txd(txd)
   );

   initial begin
      forever begin
         @(negedge clk) var_tick = 1'b1;
         @(negedge clk) var_tick = 1'b0;
      end
   end

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic ctl_write(input logic [7:0] v);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
      ctl_sh = v;
   endtask

   task automatic data_write(input logic [7:0] d);
      @(negedge clk);
      data_wr = 1'b1;
      data_wdata = d;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   // driver: pushes the expected frame, then writes the byte
   task automatic tx_send(input logic [7:0] d, input bit poke);
      ctl_write(ctl_sh);
      mon_nine = ctl_sh[7];
      exp_q.push_back(ctl_sh[7] ? {ctl_sh[3], d} : {1'b0, d});
      pushed++;
      data_write(d);
      if (poke) begin
         repeat (3 * bit_clks) @(negedge clk);
         data_write(8'hFF);
      end
      while (frames_seen != pushed) @(negedge clk);
      repeat (2 * bit_clks) @(negedge clk);
   endtask

   // monitor: decodes txd and compares with the scoreboard queue
   initial begin
      logic [8:0] got;
      logic [8:0] e;
      logic       nl;
      forever begin
         @(negedge txd);
         nl = mon_nine;
         got = '0;
         repeat (bit_clks / 2) @(negedge clk);
         chk("R7 start bit", 16'(txd), 16'd0);
         for (int i = 0; i < 9; i++) begin
            if (i == 8 && !nl) break;
            repeat (bit_clks) @(negedge clk);
            got[i] = txd;
            if (i == (nl ? 8 : 7)) chk("R5 tx flag before stop", 16'(ctl_rdata[1]), 16'd0);
         end
         repeat (bit_clks) @(negedge clk);
         chk("R7 stop bit", 16'(txd), 16'd1);
         chk("R5 tx flag in stop", 16'(ctl_rdata[1]), 16'd1);
         if (exp_q.size() == 0) chk("R8 unexpected frame", 16'd1, 16'd0);
         else begin
            e = exp_q.pop_front();
            chk("R3/R7/R10 tx frame", 16'(got), 16'(e));
         end
         frames_seen++;
      end
   end

   task automatic rx_frame(input logic [8:0] d9, input logic stopv, input logic exp_ri,
                           input bit glitch, input string tag);
      int nb;
      nb = ctl_sh[7] ? 9 : 8;
      ctl_write(ctl_sh);
      @(negedge clk);
      rxd = 1'b0;
      repeat (bit_clks) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rxd = d9[i];
         if (glitch && i == 2) begin
            repeat (bit_clks / 2 - 1) @(negedge clk);
            rxd = ~d9[i];
            repeat (2) @(negedge clk);
            rxd = d9[i];
            repeat (bit_clks / 2 - 1) @(negedge clk);
         end else begin
            repeat (bit_clks) @(negedge clk);
         end
      end
      rxd = stopv;
      repeat (3 * bit_clks / 8) @(negedge clk);
      chk("R6 rx flag clear early in stop", 16'(ctl_rdata[0]), 16'd0);
      repeat (13 * bit_clks / 16 - 3 * bit_clks / 8) @(negedge clk);
      chk(tag, 16'(ctl_rdata[0]), 16'(exp_ri));
      repeat (bit_clks - 13 * bit_clks / 16) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * bit_clks) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int lows;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ctl reset", 16'(ctl_rdata), 16'h00);
      chk("R1 txd idle", 16'(txd), 16'd1);
      chk("R1 rx_data reset", 16'(rx_data), 16'h00);

      // R2 register read back (format 00 keeps the port inactive)
      ctl_write(8'h3C);
      chk("R2 readback", 16'(ctl_rdata), 16'h3C);
      ctl_write(8'h00);
      chk("R2 readback clear", 16'(ctl_rdata), 16'h00);

      // R8 data write in inactive format
      data_write(8'h55);
      lows = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (txd == 1'b0) lows++;
      end
      chk("R8 inactive write ignored", 16'(lows), 16'd0);

      // 8-bit variable rate transmit
      bit_clks = 32;
      ctl_sh = 8'h40;
      tx_send(8'hA5, 1'b0);
      tx_send(8'h01, 1'b0);
      tx_send(8'h80, 1'b1);
      repeat (12 * bit_clks) @(negedge clk);
      chk("R8 busy write ignored", 16'(frames_seen), 16'(pushed));
      chk("R8 no extra frame queued", 16'(exp_q.size()), 16'd0);

      // 9-bit variable rate transmit, ninth bit 1 and 0 (R3)
      ctl_sh = 8'hC8;
      tx_send(8'h3C, 1'b0);
      ctl_sh = 8'hC0;
      tx_send(8'hC3, 1'b0);

      // R10 fixed rate, normal and doubled
      bit_clks = 64;
      ctl_sh = 8'h88;
      tx_send(8'h5A, 1'b0);
      rate_dbl = 1'b1;
      bit_clks = 32;
      tx_send(8'h96, 1'b0);
      rate_dbl = 1'b0;

      // receive, 8-bit, filter off
      bit_clks = 32;
      ctl_sh = 8'h50;
      rx_frame(9'h05A, 1'b1, 1'b1, 1'b0, "R6 rx flag set");
      chk("R7 rx data", 16'(rx_data), 16'h5A);
      chk("R4 stop into ninth", 16'(ctl_rdata[2]), 16'd1);
      repeat (200) @(negedge clk);
      chk("R6 rx flag sticky", 16'(ctl_rdata[0]), 16'd1);
      chk("R6 tx flag sticky", 16'(ctl_rdata[1]), 16'd0);

      // R9 receive disabled
      ctl_sh = 8'h40;
      rx_frame(9'h033, 1'b1, 1'b0, 1'b0, "R9 no flag when disabled");
      chk("R9 data kept", 16'(rx_data), 16'h5A);

      // R4 bad stop with filter off then on
      ctl_sh = 8'h50;
      rx_frame(9'h00F, 1'b0, 1'b1, 1'b0, "R4 bad stop accepted unfiltered");
      chk("R4 bad stop data", 16'(rx_data), 16'h0F);
      chk("R4 bad stop ninth", 16'(ctl_rdata[2]), 16'd0);
      ctl_sh = 8'h70;
      rx_frame(9'h0F0, 1'b0, 1'b0, 1'b0, "R4 bad stop dropped");
      chk("R4 dropped data kept", 16'(rx_data), 16'h0F);
      rx_frame(9'h0F0, 1'b1, 1'b1, 1'b0, "R4 good stop filtered");
      chk("R4 filtered good data", 16'(rx_data), 16'hF0);

      // R3 9-bit filter
      ctl_sh = 8'hF0;
      rx_frame(9'h0AA, 1'b1, 1'b0, 1'b0, "R3 ninth 0 dropped");
      chk("R3 dropped data kept", 16'(rx_data), 16'hF0);
      chk("R3 dropped ninth kept", 16'(ctl_rdata[2]), 16'd0);
      rx_frame(9'h155, 1'b1, 1'b1, 1'b0, "R3 ninth 1 accepted");
      chk("R3 address data", 16'(rx_data), 16'h55);
      chk("R3 ninth stored", 16'(ctl_rdata[2]), 16'd1);
      ctl_sh = 8'hD0;
      rx_frame(9'h066, 1'b1, 1'b1, 1'b0, "R3 unfiltered ninth 0");
      chk("R3 unfiltered ninth", 16'(ctl_rdata[2]), 16'd0);
      chk("R3 unfiltered data", 16'(rx_data), 16'h66);

      // R11 short start pulse, then centre glitch
      ctl_sh = 8'h50;
      ctl_write(ctl_sh);
      @(negedge clk);
      rxd = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      repeat (12 * bit_clks) @(negedge clk);
      chk("R11 short start ignored", 16'(ctl_rdata[0]), 16'd0);
      chk("R11 short start data kept", 16'(rx_data), 16'h66);
      rx_frame(9'h0C5, 1'b1, 1'b1, 1'b1, "R11 glitch frame flag");
      chk("R11 glitch outvoted", 16'(rx_data), 16'hC5);

      // R10 fixed-rate receive
      bit_clks = 64;
      ctl_sh = 8'h90;
      rx_frame(9'h1E7, 1'b1, 1'b1, 1'b0, "R10 fixed rate rx flag");
      chk("R10 fixed rate rx data", 16'(rx_data), 16'hE7);
      chk("R10 fixed rate ninth", 16'(ctl_rdata[2]), 16'd1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule